// File: doc/BRIEF.md
# Masked-Field Delta Update Register File

This block holds the parameter registers of a speech synthesis engine: an 8-bit amplitude (3-bit exponent in bits 7:5 over a 5-bit mantissa in bits 4:0), an 8-bit pitch period, and six pairs of 8-bit filter coefficients, each pair made of a B and an F coefficient. Upstream, a stream parser decodes delta-update instructions into records. Each record carries a variant flag, a 2-bit format mode, the current repeat count, an amplitude delta, a pitch delta and one small signed delta for each coefficient slot.

The block has a built-in table, indexed by variant and mode, that says how many most-significant bits of each coefficient a record updates. The delta for a slot is aligned to the lowest of those bits and added there. The sum wraps inside the group of updated bits, and the bits below the group keep their old values. The amplitude and pitch deltas are handled differently. They are added across the whole register, so a carry out of the amplitude mantissa moves into the exponent. All writes for one record land in the same clock edge, and a one-cycle completion pulse follows one cycle after that edge.

Top module: `dlu_delta_regfile`

## Requirements
- R1: After a synchronous active-high reset, every parameter register reads zero and `done_o` is low.
- R2: An applied record adds the 4-bit two's-complement `amp_delta_i`, sign-extended to 8 bits, to the whole amplitude register modulo 256. A mantissa carry or borrow therefore changes bits 7:5.
- R3: An applied record adds the 5-bit two's-complement `pitch_delta_i`, sign-extended, to the whole pitch register modulo 256.
- R4: A coefficient updated in its top n bits keeps its low 8-n bits unchanged.
- R5: The top n bits of a coefficient are treated as an n-bit group. The 5-bit signed slot delta is added to that group modulo 2^n, with no saturation, so the group's maximum plus one gives zero.
- R6: Slot s of `coef_delta_i[5*s +: 5]` and `coef_o[8*s +: 8]` is B of pair s/2 for even s and F for odd s. With `rec_short_i`=0 and mode bit 1 = 0, the widths are B0..B2 4, F0..F2 5, B3 5, F3 6, B4 6, F4 6.
- R7: With `rec_short_i`=0 and mode bit 1 = 1, the widths are B0..B2 7, F0..F2 6, B3 7, F3 7, B4 8, F4 8.
- R8: Pair 5 (slots 10 and 11) is updated with 8 bits each when mode bit 0 = 1. When mode bit 0 = 0 it is left unchanged, in both variants.
- R9: With `rec_short_i`=1, pairs 0 to 2 are unchanged. The widths are B3 5, F3 6, B4 7, F4 6 when mode bit 1 = 0, and B3 7, F3 7, B4 8, F4 8 when mode bit 1 = 1.
- R10: A record presented with `rec_repeat_i` = 0 writes no register and raises no completion pulse.
- R11: A record presented for one cycle with a repeat count of at least 1 is applied exactly once, whatever the count. The new values appear after that clock edge. `done_o` is high for exactly one cycle, starting one edge later.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid_i | input | 1 | Delta record present this cycle |
| rec_short_i | input | 1 | 1 = three-pair variant (pairs 3..5), 0 = six-pair variant |
| rec_mode_i | input | 2 | Format mode selecting update widths |
| rec_repeat_i | input | 6 | Current repeat count |
| amp_delta_i | input | 4 | Signed amplitude delta |
| pitch_delta_i | input | 5 | Signed pitch delta |
| coef_delta_i | input | 60 | Twelve 5-bit signed slot deltas, slot s at [5*s +: 5] |
| amp_o | output | 8 | Amplitude register |
| pitch_o | output | 8 | Pitch register |
| coef_o | output | 96 | Twelve coefficient registers, slot s at [8*s +: 8] |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every variant and mode with pseudo-random deltas over registers whose low bits were set earlier by wider updates. A design that masked the wrong bits would therefore clobber those low bits, and one that wrapped at 8 bits instead of within the group would carry into them. Amplitude deltas of every value are applied repeatedly, so a design that masked the mantissa would stop the exponent from moving. Pair 5 is checked in both settings of the mode bit, and pairs 0 to 2 are checked under the three-pair variant, where a shared width table could leak updates into them. A zero repeat count and a large repeat count are both exercised: a design that wrote on a zero count, or re-applied the delta each cycle, would show wrong register values or an extra completion pulse.

// File: rtl/dlu_pkg.sv
package dlu_pkg;

    localparam int REG_W   = 8;
    localparam int NPAIR   = 6;
    localparam int NSLOT   = 2 * NPAIR;
    localparam int CDW     = 5;
    localparam int ADW     = 4;
    localparam int PDW     = 5;
    localparam int WW      = $clog2(REG_W + 1);
    localparam int REP_W   = 6;

    typedef logic [WW-1:0] fwidth_t;

    // Number of MSBs a record updates in coefficient slot `slot`.
    function automatic fwidth_t slot_width(logic short_v, logic [1:0] mode, int slot);
        int  pair;
        logic is_f;
        int  w;
        pair = slot / 2;
        is_f = (slot % 2) == 1;
        w = 0;
        if (pair == 5) begin
            w = mode[0] ? 8 : 0;
        end else if (short_v) begin
            if (pair == 3)      w = mode[1] ? 7 : (is_f ? 6 : 5);
            else if (pair == 4) w = mode[1] ? 8 : (is_f ? 6 : 7);
            else                w = 0;
        end else begin
            if (pair < 3)       w = mode[1] ? (is_f ? 6 : 7) : (is_f ? 5 : 4);
            else if (pair == 3) w = mode[1] ? 7 : (is_f ? 6 : 5);
            else                w = mode[1] ? 8 : 6;
        end
        return fwidth_t'(w);
    endfunction

endpackage

// File: rtl/dlu_width_table.sv
module dlu_width_table
    import dlu_pkg::*;
(
    input  logic                  short_i,
    input  logic [1:0]            mode_i,
    output logic [NSLOT*WW-1:0]   width_o
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign width_o[s*WW +: WW] = slot_width(short_i, mode_i, s);
    end
endmodule

// File: rtl/dlu_field_add.sv
module dlu_field_add #(
    parameter int REG_W = 8,
    parameter int DW    = 5,
    localparam int SW   = $clog2(REG_W + 1)
) (
    input  logic [REG_W-1:0] old_i,
    input  logic [DW-1:0]    delta_i,
    input  logic [SW-1:0]    width_i,
    output logic [REG_W-1:0] new_o
);
    logic [REG_W-1:0] ext;
    logic [REG_W-1:0] sum;
    logic [REG_W-1:0] keep;
    logic [SW-1:0]    shamt;

    always_comb begin
        ext   = {{(REG_W-DW){delta_i[DW-1]}}, delta_i};
        shamt = SW'(REG_W) - width_i;
        sum   = '0;
        keep  = '1;
        if (width_i != '0) begin
            sum  = old_i + (ext << shamt);
            keep = (REG_W'(1) << shamt) - REG_W'(1);
        end
        new_o = (sum & ~keep) | (old_i & keep);
    end
endmodule

// File: rtl/dlu_delta_regfile.sv
module dlu_delta_regfile
    import dlu_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rec_valid_i,
    input  logic                   rec_short_i,
    input  logic [1:0]             rec_mode_i,
    input  logic [REP_W-1:0]       rec_repeat_i,
    input  logic [ADW-1:0]         amp_delta_i,
    input  logic [PDW-1:0]         pitch_delta_i,
    input  logic [NSLOT*CDW-1:0]   coef_delta_i,
    output logic [REG_W-1:0]       amp_o,
    output logic [REG_W-1:0]       pitch_o,
    output logic [NSLOT*REG_W-1:0] coef_o,
    output logic                   done_o
);
    logic [NSLOT*WW-1:0]    widths;
    logic [NSLOT*REG_W-1:0] coef_next;
    logic [REG_W-1:0]       amp_next;
    logic [REG_W-1:0]       pitch_next;
    logic                   apply;
    logic                   applied_q;

    assign apply = rec_valid_i && (rec_repeat_i != '0);

    dlu_width_table u_tab (
        .short_i (rec_short_i),
        .mode_i  (rec_mode_i),
        .width_o (widths)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_coef
        dlu_field_add #(.REG_W(REG_W), .DW(CDW)) u_add (
            .old_i   (coef_o[s*REG_W +: REG_W]),
            .delta_i (coef_delta_i[s*CDW +: CDW]),
            .width_i (widths[s*WW +: WW]),
            .new_o   (coef_next[s*REG_W +: REG_W])
        );
    end

    // Whole-register adds: carries are free to cross the mantissa/exponent line.
    always_comb begin
        amp_next   = amp_o + {{(REG_W-ADW){amp_delta_i[ADW-1]}}, amp_delta_i};
        pitch_next = pitch_o + {{(REG_W-PDW){pitch_delta_i[PDW-1]}}, pitch_delta_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_o     <= '0;
            pitch_o   <= '0;
            coef_o    <= '0;
            applied_q <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            applied_q <= apply;
            done_o    <= applied_q;
            if (apply) begin
                amp_o   <= amp_next;
                pitch_o <= pitch_next;
                coef_o  <= coef_next;
            end
        end
    end
endmodule

// File: rtl/dlu_delta_regfile_chk.sv
module dlu_delta_regfile_chk
    import dlu_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   rec_valid_i,
    input logic                   rec_short_i,
    input logic [1:0]             rec_mode_i,
    input logic [REP_W-1:0]       rec_repeat_i,
    input logic [ADW-1:0]         amp_delta_i,
    input logic [PDW-1:0]         pitch_delta_i,
    input logic [NSLOT*REG_W-1:0] coef_o,
    input logic [REG_W-1:0]       amp_o,
    input logic [REG_W-1:0]       pitch_o,
    input logic                   done_o
);
    logic go;
    assign go = rec_valid_i && (rec_repeat_i != '0);

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !go |=> ($stable(amp_o) && $stable(pitch_o) && $stable(coef_o)));

    assert_amp_whole_add_R2: assert property (@(posedge clk) disable iff (rst)
        go |=> amp_o == REG_W'($past(amp_o) + {{(REG_W-ADW){$past(amp_delta_i[ADW-1])}}, $past(amp_delta_i)}));

    assert_pitch_whole_add_R3: assert property (@(posedge clk) disable iff (rst)
        go |=> pitch_o == REG_W'($past(pitch_o) + {{(REG_W-PDW){$past(pitch_delta_i[PDW-1])}}, $past(pitch_delta_i)}));

    assert_b0_low_bits_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (go && !rec_short_i && !rec_mode_i[1]) |=> coef_o[3:0] == $past(coef_o[3:0]));

    assert_short_low_pairs_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (go && rec_short_i) |=> $stable(coef_o[6*REG_W-1:0]));

    assert_pair5_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (go && !rec_mode_i[0]) |=> $stable(coef_o[NSLOT*REG_W-1:10*REG_W]));

    assert_done_follows_write_R11: assert property (@(posedge clk) disable iff (rst)
        go |=> ##1 done_o);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

bind dlu_delta_regfile dlu_delta_regfile_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .rec_valid_i   (rec_valid_i),
    .rec_short_i   (rec_short_i),
    .rec_mode_i    (rec_mode_i),
    .rec_repeat_i  (rec_repeat_i),
    .amp_delta_i   (amp_delta_i),
    .pitch_delta_i (pitch_delta_i),
    .coef_o        (coef_o),
    .amp_o         (amp_o),
    .pitch_o       (pitch_o),
    .done_o        (done_o)
);

// File: tb/dlu_delta_regfile_tb.sv
module dlu_delta_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rec_valid_i = 1'b0;
    logic        rec_short_i = 1'b0;
    logic [1:0]  rec_mode_i = 2'b00;
    logic [5:0]  rec_repeat_i = 6'd0;
    logic [3:0]  amp_delta_i = '0;
    logic [4:0]  pitch_delta_i = '0;
    logic [59:0] coef_delta_i = '0;
    logic [7:0]  amp_o, pitch_o;
    logic [95:0] coef_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [31:0] seed = 32'h1234_5678;

    int m_amp, m_pitch;
    int m_coef [12];

    always #10 clk = ~clk;

    dlu_delta_regfile u_dut (
        .clk(clk), .rst(rst), .rec_valid_i(rec_valid_i), .rec_short_i(rec_short_i),
        .rec_mode_i(rec_mode_i), .rec_repeat_i(rec_repeat_i), .amp_delta_i(amp_delta_i),
        .pitch_delta_i(pitch_delta_i), .coef_delta_i(coef_delta_i), .amp_o(amp_o),
        .pitch_o(pitch_o), .coef_o(coef_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return int'(seed & 32'h7fff_ffff);
    endfunction

    // Update widths taken from R6..R9.
    function automatic int width_of(bit sh, logic [1:0] md, int s);
        int p = s / 2;
        bit f = (s % 2) == 1;
        if (p == 5) return md[0] ? 8 : 0;
        if (sh && p < 3) return 0;
        if (sh && p == 4) return md[1] ? 8 : (f ? 6 : 7);
        if (p == 3) return md[1] ? 7 : (f ? 6 : 5);
        if (p == 4) return md[1] ? 8 : 6;
        return md[1] ? (f ? 6 : 7) : (f ? 5 : 4);
    endfunction

    function automatic int sx(int v, int bits);
        return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
    endfunction

    function automatic string tag_of(bit sh, logic [1:0] md, int s);
        if (s >= 10) return "R8";
        if (sh) return "R9";
        return md[1] ? "R7" : "R6";
    endfunction

    task automatic check_all(input bit sh, input logic [1:0] md);
        chk("R2 amp", int'(amp_o), m_amp);
        chk("R3 pitch", int'(pitch_o), m_pitch);
        for (int s = 0; s < 12; s++)
            chk(tag_of(sh, md, s), int'(coef_o[8*s +: 8]), m_coef[s]);
    endtask

    task automatic send(input bit sh, input logic [1:0] md, input logic [5:0] rep,
                        input logic [3:0] ad, input logic [4:0] pd, input logic [59:0] cd);
        rec_valid_i   = 1'b1;
        rec_short_i   = sh;
        rec_mode_i    = md;
        rec_repeat_i  = rep;
        amp_delta_i   = ad;
        pitch_delta_i = pd;
        coef_delta_i  = cd;
        if (rep != 0) begin
            m_amp   = (m_amp + sx(int'(ad), 4)) & 255;
            m_pitch = (m_pitch + sx(int'(pd), 5)) & 255;
            for (int s = 0; s < 12; s++) begin
                int n = width_of(sh, md, s);
                if (n > 0) begin
                    int lo = m_coef[s] & ((1 << (8 - n)) - 1);
                    int g  = (m_coef[s] >> (8 - n)) + sx(int'(cd[5*s +: 5]), 5);
                    g = g & ((1 << n) - 1);
                    m_coef[s] = (g << (8 - n)) | lo;
                end
            end
        end
        @(negedge clk);
        rec_valid_i = 1'b0;
        check_all(sh, md);
        chk("R11 done early", int'(done_o), 0);
        @(negedge clk);
        chk(rep != 0 ? "R11 done pulse" : "R10 no done", int'(done_o), rep != 0 ? 1 : 0);
    endtask

    initial begin
        m_amp = 0; m_pitch = 0;
        for (int s = 0; s < 12; s++) m_coef[s] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 amp", int'(amp_o), 0);
        chk("R1 pitch", int'(pitch_o), 0);
        chk("R1 coef", (coef_o == '0) ? 0 : 1, 0);
        chk("R1 done", int'(done_o), 0);

        // R5: B0 group of 4 at zero minus one wraps to all ones, then back to zero.
        send(1'b0, 2'b00, 6'd1, 4'd0, 5'd0, 60'h1F);
        chk("R5 wrap down", int'(coef_o[7:0]), 8'hF0);
        send(1'b0, 2'b00, 6'd1, 4'd0, 5'd0, 60'h01);
        chk("R5 max plus one", int'(coef_o[7:0]), 8'h00);
        // R4: a 7-bit update leaves low bits that a later 4-bit update must keep.
        send(1'b0, 2'b10, 6'd1, 4'd0, 5'd0, 60'h05);
        chk("R4 seven bit", int'(coef_o[7:0]), 8'h0A);
        send(1'b0, 2'b00, 6'd1, 4'd0, 5'd0, 60'h01);
        chk("R4 low bits kept", int'(coef_o[7:0]), 8'h1A);

        // R2: every amplitude delta, repeatedly, so carries reach the exponent.
        for (int r = 0; r < 6; r++)
            for (int d = 0; d < 16; d++)
                send(1'b0, 2'b00, 6'd1, 4'(d), 5'(r), '0);

        // R6..R9 sweep over variant and mode.
        for (int v = 0; v < 8; v++)
            for (int k = 0; k < 30; k++) begin
                logic [59:0] cd;
                for (int s = 0; s < 12; s++) cd[5*s +: 5] = 5'(rnd());
                send(v[2], 2'(v), 6'(1 + (rnd() % 63)), 4'(rnd()), 5'(rnd()), cd);
            end

        // R10: zero repeat count changes nothing.
        send(1'b0, 2'b11, 6'd0, 4'h7, 5'h0F, {12{5'h0B}});
        chk("R10 ignored amp", int'(amp_o), m_amp);

        // R11: large repeat count still applies once; outputs then hold.
        send(1'b0, 2'b11, 6'd63, 4'h3, 5'h02, {12{5'h01}});
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11 held amp", int'(amp_o), m_amp);
            chk("R11 held coef", int'(coef_o[95:88]), m_coef[11]);
            chk("R11 single pulse", int'(done_o), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule